// File: doc/BRIEF.md
# Counted Memory Block-Copy Engine

This engine moves a run of bytes from one region of a single-port byte memory to another. A caller gives a source pointer, a destination pointer, a byte count and a count-width select, then pulses `start`. The engine holds `busy` high and works through one byte every four cycles. In each byte slot it reads from the source, keeps the byte, writes it to the destination, and then advances both pointers and lowers the count. When the count reaches zero it pulses `done` for one cycle.

The select picks an 8-bit count, which moves at most 255 bytes, or a 16-bit count, which moves at most 65535 bytes. A zero count causes no memory traffic. The run time is exact: a fixed cost of 8 cycles plus 4 cycles per byte. Once the run ends, the updated pointers and the count stay on the outputs, so the caller can chain a further copy from where this one stopped.

Top module: `blkcopy_engine`

## Requirements
- R1: After reset `busy`, `done` and `mem_req` are low and `cnt_out` is zero. While the engine is not busy it makes no memory request.
- R2: A start whose effective count is zero makes no memory request. `done` follows after exactly 8 busy cycles.
- R3: Each byte slot lasts four cycles. A read request (`mem_req`=1, `mem_we`=0) at the source pointer comes in the first cycle. The read data is captured in the second cycle. A write request (`mem_req`=1, `mem_we`=1) at the destination pointer comes in the third cycle. The memory returns read data one cycle after the request.
- R4: After each byte, both pointers rise by exactly one and wrap modulo 2^16. At completion `src_out` = start source + n and `dst_out` = start destination + n.
- R5: After each byte the count falls by one. Copying ends when the count is zero, so `cnt_out` is zero whenever `done` is high.
- R6: When `mode_word`=0, only `cnt_in[7:0]` is used and `cnt_in[15:8]` is ignored.
- R7: When `mode_word`=1, all 16 bits of `cnt_in` form the count.
- R8: `busy` stays high for exactly 8+4n cycles. `done` is a one-cycle pulse in the last busy cycle, and `busy` is low in the cycle after it.
- R9: A `start` pulse that arrives while `busy` is high is ignored. It changes neither the pointers, the count nor the timing.
- R10: Each write carries the byte that the read request of the same slot returned. Overlapping regions are therefore copied in forward order, one byte at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a copy; honoured only while idle |
| mode_word | input | 1 | 1 = 16-bit count, 0 = 8-bit count |
| src_in | input | 16 | Initial source pointer |
| dst_in | input | 16 | Initial destination pointer |
| cnt_in | input | 16 | Byte count (low 8 bits only when `mode_word`=0) |
| busy | output | 1 | Copy in progress |
| done | output | 1 | One-cycle completion pulse |
| src_out | output | 16 | Current or final source pointer |
| dst_out | output | 16 | Current or final destination pointer |
| cnt_out | output | 16 | Current or final remaining count |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid one cycle after a read request |

## Verification
A slot phase that has drifted shows at once on the memory port. A write can appear without a read two cycles before it, or it can carry a byte other than the one just returned. Either fault is visible within the same byte slot. A pointer or count that steps wrongly shows up on the next address the engine puts out, within four cycles. A bad count also changes the total busy length, which the bench compares against 8+4n when `done` arrives. An overhead counter that is off by one, or a zero-count path that still starts a slot, shows only at completion: `done` arrives early or late, or a memory request appears where none was expected.

// File: rtl/blkcopy_pkg.sv
package blkcopy_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PRE  = 2'd1,
    ST_XFER = 2'd2,
    ST_POST = 2'd3
  } bc_state_e;

  typedef enum logic [1:0] {
    PH_READ  = 2'd0,
    PH_GRAB  = 2'd1,
    PH_WRITE = 2'd2,
    PH_STEP  = 2'd3
  } bc_phase_e;

endpackage

// File: rtl/blkcopy_ctrl.sv
module blkcopy_ctrl
  import blkcopy_pkg::*;
#(
  parameter int PRE_CYC  = 4,
  parameter int POST_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic cnt_is_zero,
  input  logic cnt_is_one,
  output logic ev_accept,
  output logic ev_rd,
  output logic ev_cap,
  output logic ev_wr,
  output logic ev_step,
  output logic ev_done,
  output logic busy
);

  localparam int OVH_MAX = (PRE_CYC > POST_CYC) ? PRE_CYC : POST_CYC;
  localparam int OVH_W   = (OVH_MAX > 1) ? $clog2(OVH_MAX) : 1;

  bc_state_e  state_q, state_d;
  bc_phase_e  phase_q, phase_d;
  logic [OVH_W-1:0] ovh_q, ovh_d;

  logic pre_last, post_last;

  assign pre_last  = (state_q == ST_PRE)  && (ovh_q == OVH_W'(PRE_CYC - 1));
  assign post_last = (state_q == ST_POST) && (ovh_q == OVH_W'(POST_CYC - 1));

  assign busy      = (state_q != ST_IDLE);
  assign ev_accept = start && (state_q == ST_IDLE);
  assign ev_rd     = (state_q == ST_XFER) && (phase_q == PH_READ);
  assign ev_cap    = (state_q == ST_XFER) && (phase_q == PH_GRAB);
  assign ev_wr     = (state_q == ST_XFER) && (phase_q == PH_WRITE);
  assign ev_step   = (state_q == ST_XFER) && (phase_q == PH_STEP);
  assign ev_done   = post_last;

  always_comb begin
    state_d = state_q;
    phase_d = phase_q;
    ovh_d   = ovh_q;
    unique case (state_q)
      ST_IDLE: begin
        if (ev_accept) begin
          state_d = ST_PRE;
          ovh_d   = '0;
        end
      end
      ST_PRE: begin
        if (pre_last) begin
          ovh_d   = '0;
          phase_d = PH_READ;
          state_d = cnt_is_zero ? ST_POST : ST_XFER;
        end else begin
          ovh_d = ovh_q + 1'b1;
        end
      end
      ST_XFER: begin
        phase_d = bc_phase_e'(phase_q + 2'd1);
        if (ev_step && cnt_is_one) begin
          state_d = ST_POST;
          ovh_d   = '0;
        end
      end
      ST_POST: begin
        if (post_last) state_d = ST_IDLE;
        else           ovh_d   = ovh_q + 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      phase_q <= PH_READ;
      ovh_q   <= '0;
    end else begin
      state_q <= state_d;
      phase_q <= phase_d;
      ovh_q   <= ovh_d;
    end
  end

endmodule

// File: rtl/blkcopy_regs.sv
module blkcopy_regs #(
  parameter int ADDR_W     = 16,
  parameter int CNT_W      = 16,
  parameter int BYTE_CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              mode_word,
  input  logic [ADDR_W-1:0] src_in,
  input  logic [ADDR_W-1:0] dst_in,
  input  logic [CNT_W-1:0]  cnt_in,
  input  logic              step,
  output logic [ADDR_W-1:0] src_q,
  output logic [ADDR_W-1:0] dst_q,
  output logic [CNT_W-1:0]  cnt_q,
  output logic              cnt_zero,
  output logic              cnt_one
);

  function automatic logic [ADDR_W-1:0] ptr_next(input logic [ADDR_W-1:0] p);
    return p + 1'b1;
  endfunction

  function automatic logic [CNT_W-1:0] cnt_next(input logic [CNT_W-1:0] c);
    return c - 1'b1;
  endfunction

  logic [CNT_W-1:0] cnt_narrow;
  logic [CNT_W-1:0] cnt_load;

  generate
    if (BYTE_CNT_W < CNT_W) begin : g_mask
      assign cnt_narrow = {{(CNT_W-BYTE_CNT_W){1'b0}}, cnt_in[BYTE_CNT_W-1:0]};
    end else begin : g_full
      assign cnt_narrow = cnt_in;
    end
  endgenerate

  assign cnt_load = mode_word ? cnt_in : cnt_narrow;
  assign cnt_zero = (cnt_q == '0);
  assign cnt_one  = (cnt_q == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0;
      dst_q <= '0;
      cnt_q <= '0;
    end else if (load) begin
      src_q <= src_in;
      dst_q <= dst_in;
      cnt_q <= cnt_load;
    end else if (step) begin
      src_q <= ptr_next(src_q);
      dst_q <= ptr_next(dst_q);
      cnt_q <= cnt_next(cnt_q);
    end
  end

endmodule

// File: rtl/blkcopy_memif.sv
module blkcopy_memif #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_rd,
  input  logic              ev_cap,
  input  logic              ev_wr,
  input  logic [ADDR_W-1:0] src,
  input  logic [ADDR_W-1:0] dst,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata
);

  logic [DATA_W-1:0] hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hold_q <= '0;
    else if (ev_cap) hold_q <= mem_rdata;
  end

  assign mem_req   = ev_rd | ev_wr;
  assign mem_we    = ev_wr;
  assign mem_addr  = ev_wr ? dst : src;
  assign mem_wdata = hold_q;

endmodule

// File: rtl/blkcopy_engine.sv
module blkcopy_engine #(
  parameter int ADDR_W     = 16,
  parameter int CNT_W      = 16,
  parameter int BYTE_CNT_W = 8,
  parameter int DATA_W     = 8,
  parameter int PRE_CYC    = 4,
  parameter int POST_CYC   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              mode_word,
  input  logic [ADDR_W-1:0] src_in,
  input  logic [ADDR_W-1:0] dst_in,
  input  logic [CNT_W-1:0]  cnt_in,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] src_out,
  output logic [ADDR_W-1:0] dst_out,
  output logic [CNT_W-1:0]  cnt_out,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);

  logic ev_accept, ev_rd, ev_cap, ev_wr, ev_step, ev_done;
  logic cnt_zero, cnt_one;

  blkcopy_ctrl #(
    .PRE_CYC (PRE_CYC),
    .POST_CYC(POST_CYC)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .cnt_is_zero(cnt_zero),
    .cnt_is_one (cnt_one),
    .ev_accept  (ev_accept),
    .ev_rd      (ev_rd),
    .ev_cap     (ev_cap),
    .ev_wr      (ev_wr),
    .ev_step    (ev_step),
    .ev_done    (ev_done),
    .busy       (busy)
  );

  blkcopy_regs #(
    .ADDR_W    (ADDR_W),
    .CNT_W     (CNT_W),
    .BYTE_CNT_W(BYTE_CNT_W)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ev_accept),
    .mode_word(mode_word),
    .src_in   (src_in),
    .dst_in   (dst_in),
    .cnt_in   (cnt_in),
    .step     (ev_step),
    .src_q    (src_out),
    .dst_q    (dst_out),
    .cnt_q    (cnt_out),
    .cnt_zero (cnt_zero),
    .cnt_one  (cnt_one)
  );

  blkcopy_memif #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_memif (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev_rd    (ev_rd),
    .ev_cap   (ev_cap),
    .ev_wr    (ev_wr),
    .src      (src_out),
    .dst      (dst_out),
    .mem_rdata(mem_rdata),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .mem_wdata(mem_wdata)
  );

  assign done = ev_done;

endmodule

// File: rtl/blkcopy_checker.sv
module blkcopy_checker #(
  parameter int ADDR_W     = 16,
  parameter int CNT_W      = 16,
  parameter int BYTE_CNT_W = 8,
  parameter int DATA_W     = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              mode_word,
  input logic              busy,
  input logic              done,
  input logic              ev_accept,
  input logic              ev_step,
  input logic [ADDR_W-1:0] src_out,
  input logic [ADDR_W-1:0] dst_out,
  input logic [CNT_W-1:0]  cnt_out,
  input logic              mem_req,
  input logic              mem_we,
  input logic [DATA_W-1:0] mem_wdata,
  input logic [DATA_W-1:0] mem_rdata
);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);

  p_zero_no_access_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt_out == '0) |-> !mem_req);

  p_write_after_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> $past(mem_req && !mem_we, 2));

  p_ptr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_step |=> (src_out == ADDR_W'($past(src_out) + 1'b1)) &&
                (dst_out == ADDR_W'($past(dst_out) + 1'b1)));

  p_cnt_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_step |=> cnt_out == CNT_W'($past(cnt_out) - 1'b1));

  p_done_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cnt_out == '0);

  p_byte_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_accept && !mode_word) |=> (cnt_out >> BYTE_CNT_W) == '0);

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy ##1 (!done && !busy));

  p_busy_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !ev_step) |=> $stable(cnt_out) && $stable(src_out));

  p_wdata_from_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> mem_wdata == $past(mem_rdata, 1));

endmodule

bind blkcopy_engine blkcopy_checker #(
  .ADDR_W    (ADDR_W),
  .CNT_W     (CNT_W),
  .BYTE_CNT_W(BYTE_CNT_W),
  .DATA_W    (DATA_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .mode_word(mode_word),
  .busy     (busy),
  .done     (done),
  .ev_accept(ev_accept),
  .ev_step  (ev_step),
  .src_out  (src_out),
  .dst_out  (dst_out),
  .cnt_out  (cnt_out),
  .mem_req  (mem_req),
  .mem_we   (mem_we),
  .mem_wdata(mem_wdata),
  .mem_rdata(mem_rdata)
);

// File: tb/test_blkcopy_engine.sv
module test_blkcopy_engine;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        mode_word = 1'b0;
  logic [15:0] src_in = '0, dst_in = '0, cnt_in = '0;
  logic        busy, done, mem_req, mem_we;
  logic [15:0] src_out, dst_out, cnt_out, mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  blkcopy_engine i_blkcopy_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .mode_word(mode_word),
    .src_in(src_in), .dst_in(dst_in), .cnt_in(cnt_in),
    .busy(busy), .done(done), .src_out(src_out), .dst_out(dst_out),
    .cnt_out(cnt_out), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  typedef struct {
    logic [15:0] src;
    logic [15:0] dst;
    int          cycles;
    int          accesses;
  } result_t;

  int checks = 0;
  int errors = 0;
  int results_seen = 0;
  bit finished = 1'b0;

  logic [7:0]  memv   [int];
  logic [7:0]  shadow [int];
  logic [15:0] exp_rd [$];
  logic [23:0] exp_wr [$];
  result_t     exp_res[$];

  function automatic logic [7:0] pat(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  // memory model: one-cycle read latency
  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) memv[int'(mem_addr)] = mem_wdata;
      else mem_rdata <= memv.exists(int'(mem_addr)) ? memv[int'(mem_addr)] : pat(mem_addr);
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor
  int cyc = 0;
  int acc = 0;
  bit prev_done = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_done) check(!busy && !done, "R8", "busy/done after pulse", {busy, done}, 0);
      prev_done = done;
      if (busy) cyc++;
      if (mem_req) begin
        acc++;
        if (!mem_we) begin
          if (exp_rd.size() == 0) check(0, "R2", "unexpected read", mem_addr, 0);
          else begin
            logic [15:0] ea;
            ea = exp_rd.pop_front();
            check(mem_addr == ea, "R3", "read address", mem_addr, ea);
          end
        end else begin
          if (exp_wr.size() == 0) check(0, "R2", "unexpected write", mem_addr, 0);
          else begin
            logic [23:0] ew;
            ew = exp_wr.pop_front();
            check(mem_addr == ew[23:8], "R3", "write address", mem_addr, ew[23:8]);
            check(mem_wdata == ew[7:0], "R10", "write data", mem_wdata, ew[7:0]);
          end
        end
      end
      if (done) begin
        if (exp_res.size() == 0) check(0, "R8", "unexpected done", 1, 0);
        else begin
          result_t r;
          r = exp_res.pop_front();
          check(src_out == r.src, "R4", "final src", src_out, r.src);
          check(dst_out == r.dst, "R4", "final dst", dst_out, r.dst);
          check(cnt_out == 16'h0, "R5", "final count", cnt_out, 0);
          check(cyc == r.cycles, "R8", "busy cycles", cyc, r.cycles);
          check(acc == r.accesses, "R2", "access count", acc, r.accesses);
        end
        cyc = 0;
        acc = 0;
        results_seen++;
      end
    end
  end

  // driver: computes expectations, pushes them, then starts the copy
  task automatic run_copy(input logic [15:0] s, input logic [15:0] d,
                          input logic [15:0] c, input bit word, input bit poke);
    int n;
    int target;
    result_t r;
    n = word ? int'(c) : int'(c[7:0]);
    for (int i = 0; i < n; i++) begin
      logic [15:0] a, b;
      logic [7:0]  v;
      a = 16'(s + 16'(i));
      b = 16'(d + 16'(i));
      v = shadow.exists(int'(a)) ? shadow[int'(a)] : pat(a);
      shadow[int'(b)] = v;
      exp_rd.push_back(a);
      exp_wr.push_back({b, v});
    end
    r.src = 16'(s + 16'(n));
    r.dst = 16'(d + 16'(n));
    r.cycles = 8 + 4 * n;
    r.accesses = 2 * n;
    exp_res.push_back(r);
    target = results_seen + 1;
    @(negedge clk);
    start = 1'b1; src_in = s; dst_in = d; cnt_in = c; mode_word = word;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (5) @(negedge clk);
      start = 1'b1; src_in = 16'h1111; dst_in = 16'h2222; cnt_in = 16'h0009; mode_word = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    wait (results_seen == target);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!busy, "R1", "busy after reset", busy, 0);
    check(!done, "R1", "done after reset", done, 0);
    check(!mem_req, "R1", "mem_req after reset", mem_req, 0);
    check(cnt_out == 0, "R1", "count after reset", cnt_out, 0);

    run_copy(16'h0100, 16'h0400, 16'h0005, 1'b0, 1'b0);   // R3 R4 R5 R8
    run_copy(16'h0200, 16'h0500, 16'h0300, 1'b0, 1'b0);   // R2 R6: effective zero
    run_copy(16'h0210, 16'h0510, 16'h1203, 1'b0, 1'b0);   // R6: three bytes
    run_copy(16'h1000, 16'h3000, 16'h0102, 1'b1, 1'b0);   // R7: 258 bytes
    run_copy(16'hFFFE, 16'hFFFC, 16'h0006, 1'b1, 1'b0);   // R4 wrap
    run_copy(16'h0800, 16'h0801, 16'h0006, 1'b0, 1'b0);   // R10 overlap
    run_copy(16'h0900, 16'h0A00, 16'h0004, 1'b0, 1'b1);   // R9 start while busy
    repeat (12) @(negedge clk);
    check(!busy, "R9", "no extra run after ignored start", busy, 0);
    run_copy(16'h0C00, 16'h0D00, 16'h0000, 1'b1, 1'b0);   // R2 word zero
    check(exp_rd.size() == 0 && exp_wr.size() == 0, "R3", "pending accesses",
          exp_rd.size() + exp_wr.size(), 0);

    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog R8 actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule